// File: doc/BRIEF.md
# Page-Indexed Sequential Stream Prefetch Trigger

This block watches the stream of miss addresses arriving at a last-level cache and decides when to ask for a line ahead of the demand stream. It keeps a small table of stream entries. The entry for an access is chosen by the address's page number modulo the table size, so each entry covers one page slot. Each entry remembers the last cache line seen in its slot and holds a signed run counter. The counter is positive for an ascending walk through consecutive lines and negative for a descending one.

Once a run of three consecutive lines in one direction is seen, every further step in that direction produces a prefetch request a fixed distance ahead (five lines by default) in the run's direction. Each request also advances an up or a down event counter. The request is a registered one-cycle pulse carrying a line-aligned address. Filling the cache with the requested line is left to the consumer. A flush input returns every stream entry to its empty state.

Top module: `stream_prefetch_trigger`

## Requirements
- R1: During and after synchronous reset, `pf_valid` is 0 and both event counters are 0. Every stream entry holds line 0 and run count 0.
- R2: The entry used for an access is `(miss_addr >> PAGE_BITS) mod NUM_STREAMS`, which is bits [14:12] by default. Two pages whose numbers differ by a multiple of NUM_STREAMS share one entry. Pages with different slot numbers keep independent runs.
- R3: An access whose line number (`miss_addr >> LINE_BITS`) equals the entry's last line changes nothing in the entry and raises no request.
- R4: With the run count at 0, the line last+1 sets it to +1 and the line last-1 sets it to -1, and neither raises a request. Any other new line keeps it at 0. In every case the last line becomes the new line.
- R5: With a positive run count, the line last+1 increments the count. When the result is +2 or more, a request for line (current line + PF_DIST) is raised and `pf_up_count` increments by one.
- R6: With a negative run count, the line last-1 decrements the count. When the result is -2 or less, a request for line (current line - PF_DIST) is raised and `pf_down_count` increments by one.
- R7: With a positive run count, any new line other than last+1 sets the count to 0, including last-1. With a negative run count, any new line other than last-1 sets the count to 0. No request is raised in either case.
- R8: A `flush` cycle zeroes every entry and leaves the event counters unchanged. A `miss_valid` strobe in the same cycle as `flush` is ignored.
- R9: The run count saturates at the signed RUN_W limits, +(2^(RUN_W-1)-1) and -2^(RUN_W-1). A long run keeps raising one request per step and never wraps to the opposite sign.
- R10: A request appears as `pf_valid` high for exactly one cycle, in the cycle after the strobe. `pf_addr` bits [LINE_BITS-1:0] are zero. The event counters change only in a cycle with `pf_valid` high, and by one in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears all stream entries |
| miss_valid | input | 1 | Miss address strobe |
| miss_addr | input | ADDR_W | Byte address of the miss |
| pf_valid | output | 1 | One-cycle prefetch request pulse |
| pf_addr | output | ADDR_W | Line-aligned prefetch address |
| pf_up_count | output | CNT_W | Number of ascending requests issued |
| pf_down_count | output | CNT_W | Number of descending requests issued |

## Verification
The bench builds runs with unaligned byte offsets and checks that each request address is rounded down to a line. A design that forwarded the byte offset would produce misaligned targets. It breaks runs with jumps and with direction reversals, where a design that turned a +2 run straight into -1 would fire early on the way back down. It interleaves pages that alias to the same entry, which must kill both runs. It also interleaves pages in different slots, which must not. The bench is built with a 4-bit run count, so a 20-line run crosses the saturation point; a counter that wraps to negative would drop requests from the ninth step on. Flush tests check both that runs restart from empty and that a strobe coinciding with flush leaves no trace.

// File: rtl/pf_pkg.sv
package pf_pkg;

  // Direction of a confirmed run step that produces a request
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } pf_dir_e;

endpackage

// File: rtl/pf_stream_table.sv
module pf_stream_table #(
  parameter int NUM_STREAMS = 8,
  parameter int LINE_W      = 26,
  parameter int RUN_W       = 8,
  localparam int IDX_W      = $clog2(NUM_STREAMS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [LINE_W-1:0]       rd_line,
  output logic signed [RUN_W-1:0] rd_run,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [LINE_W-1:0]       wr_line,
  input  logic signed [RUN_W-1:0] wr_run
);

  logic [LINE_W-1:0]       line_q [NUM_STREAMS];
  logic signed [RUN_W-1:0] run_q  [NUM_STREAMS];

  // Clear has priority over a write in the same cycle
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int i = 0; i < NUM_STREAMS; i++) begin
        line_q[i] <= '0;
        run_q[i]  <= '0;
      end
    end else if (wr_en) begin
      line_q[wr_idx] <= wr_line;
      run_q[wr_idx]  <= wr_run;
    end
  end

  // Asynchronous read keeps the read-modify-write within one cycle
  assign rd_line = line_q[rd_idx];
  assign rd_run  = run_q[rd_idx];

  // R8: after a clear cycle every entry reads back empty
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> (rd_line == '0 && rd_run == '0));

endmodule

// File: rtl/pf_run_tracker.sv
module pf_run_tracker
  import pf_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int RUN_W  = 8
) (
  input  logic [LINE_W-1:0]       cur_line,
  input  logic [LINE_W-1:0]       last_line,
  input  logic signed [RUN_W-1:0] cur_run,
  output logic                    line_changed,
  output logic signed [RUN_W-1:0] next_run,
  output pf_dir_e                 fire_dir
);

  localparam logic signed [RUN_W-1:0] RUN_ZERO = '0;
  localparam logic signed [RUN_W-1:0] RUN_ONE  = RUN_W'(1);
  localparam logic signed [RUN_W-1:0] RUN_TWO  = RUN_W'(2);
  localparam logic signed [RUN_W-1:0] RUN_NEG1 = -RUN_ONE;
  localparam logic signed [RUN_W-1:0] RUN_NEG2 = -RUN_TWO;
  localparam logic signed [RUN_W-1:0] RUN_MAX  = {1'b0, {(RUN_W-1){1'b1}}};
  localparam logic signed [RUN_W-1:0] RUN_MIN  = {1'b1, {(RUN_W-1){1'b0}}};

  logic step_up;
  logic step_dn;
  logic signed [RUN_W-1:0] run_inc;
  logic signed [RUN_W-1:0] run_dec;

  always_comb begin
    step_up      = (cur_line == last_line + LINE_W'(1));
    step_dn      = (cur_line == last_line - LINE_W'(1));
    line_changed = (cur_line != last_line);
    run_inc      = (cur_run == RUN_MAX) ? RUN_MAX : cur_run + RUN_ONE;
    run_dec      = (cur_run == RUN_MIN) ? RUN_MIN : cur_run - RUN_ONE;
    next_run     = cur_run;
    fire_dir     = DIR_NONE;
    if (line_changed) begin
      if (cur_run == RUN_ZERO) begin
        if (step_up)      next_run = RUN_ONE;
        else if (step_dn) next_run = RUN_NEG1;
        else              next_run = RUN_ZERO;
      end else if (!cur_run[RUN_W-1]) begin
        if (step_up) begin
          next_run = run_inc;
          if (run_inc >= RUN_TWO) fire_dir = DIR_UP;
        end else begin
          next_run = RUN_ZERO;
        end
      end else begin
        if (step_dn) begin
          next_run = run_dec;
          if (run_dec <= RUN_NEG2) fire_dir = DIR_DOWN;
        end else begin
          next_run = RUN_ZERO;
        end
      end
    end
  end

endmodule

// File: rtl/pf_request_gen.sv
module pf_request_gen
  import pf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6,
  parameter int PF_DIST   = 5,
  parameter int CNT_W     = 32,
  localparam int LINE_W   = ADDR_W - LINE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  pf_dir_e           fire_dir,
  input  logic [LINE_W-1:0] cur_line,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [CNT_W-1:0]  pf_up_count,
  output logic [CNT_W-1:0]  pf_down_count
);

  localparam logic [LINE_W-1:0] DIST = LINE_W'(PF_DIST);

  logic [LINE_W-1:0] target_line;

  always_comb begin
    target_line = (fire_dir == DIR_DOWN) ? cur_line - DIST : cur_line + DIST;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid      <= 1'b0;
      pf_addr       <= '0;
      pf_up_count   <= '0;
      pf_down_count <= '0;
    end else begin
      pf_valid <= 1'b0;
      if (accept && fire_dir != DIR_NONE) begin
        pf_valid <= 1'b1;
        pf_addr  <= {target_line, {LINE_BITS{1'b0}}};
        if (fire_dir == DIR_UP) pf_up_count   <= pf_up_count + CNT_W'(1);
        else                    pf_down_count <= pf_down_count + CNT_W'(1);
      end
    end
  end

  // R10: a request only follows an accepted strobe
  p_valid_after_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> $past(accept));

  // R10: counters move only with a request
  p_counts_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !pf_valid |-> ($stable(pf_up_count) && $stable(pf_down_count)));

  // R10: exactly one counter step per request
  p_one_step_r10: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> ((pf_up_count - $past(pf_up_count))
                + (pf_down_count - $past(pf_down_count))) == CNT_W'(1));

  // R5: an ascending request targets the line PF_DIST ahead
  p_up_target_r5: assert property (@(posedge clk) disable iff (rst)
    (pf_up_count != $past(pf_up_count)) |->
      pf_addr[ADDR_W-1:LINE_BITS] == $past(cur_line) + DIST);

  // R6: a descending request targets the line PF_DIST behind
  p_down_target_r6: assert property (@(posedge clk) disable iff (rst)
    (pf_down_count != $past(pf_down_count)) |->
      pf_addr[ADDR_W-1:LINE_BITS] == $past(cur_line) - DIST);

endmodule

// File: rtl/stream_prefetch_trigger.sv
module stream_prefetch_trigger
  import pf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_BYTES  = 64,
  parameter int PAGE_BITS   = 12,
  parameter int NUM_STREAMS = 8,
  parameter int RUN_W       = 8,
  parameter int PF_DIST     = 5,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [CNT_W-1:0]  pf_up_count,
  output logic [CNT_W-1:0]  pf_down_count
);

  localparam int LINE_BITS = $clog2(LINE_BYTES);
  localparam int LINE_W    = ADDR_W - LINE_BITS;
  localparam int IDX_W     = $clog2(NUM_STREAMS);

  logic [IDX_W-1:0]        slot;
  logic [LINE_W-1:0]       cur_line;
  logic [LINE_W-1:0]       last_line;
  logic signed [RUN_W-1:0] cur_run;
  logic signed [RUN_W-1:0] next_run;
  logic                    line_changed;
  logic                    accept;
  pf_dir_e                 fire_dir;
  logic                    unused_offset;

  assign slot          = miss_addr[PAGE_BITS +: IDX_W];
  assign cur_line      = miss_addr[ADDR_W-1:LINE_BITS];
  assign accept        = miss_valid && !flush;
  assign unused_offset = ^miss_addr[LINE_BITS-1:0];

  pf_stream_table #(
    .NUM_STREAMS (NUM_STREAMS),
    .LINE_W      (LINE_W),
    .RUN_W       (RUN_W)
  ) u_table (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .rd_idx  (slot),
    .rd_line (last_line),
    .rd_run  (cur_run),
    .wr_en   (accept && line_changed),
    .wr_idx  (slot),
    .wr_line (cur_line),
    .wr_run  (next_run)
  );

  pf_run_tracker #(
    .LINE_W (LINE_W),
    .RUN_W  (RUN_W)
  ) u_tracker (
    .cur_line     (cur_line),
    .last_line    (last_line),
    .cur_run      (cur_run),
    .line_changed (line_changed),
    .next_run     (next_run),
    .fire_dir     (fire_dir)
  );

  pf_request_gen #(
    .ADDR_W    (ADDR_W),
    .LINE_BITS (LINE_BITS),
    .PF_DIST   (PF_DIST),
    .CNT_W     (CNT_W)
  ) u_req (
    .clk           (clk),
    .rst           (rst),
    .accept        (accept),
    .fire_dir      (fire_dir),
    .cur_line      (cur_line),
    .pf_valid      (pf_valid),
    .pf_addr       (pf_addr),
    .pf_up_count   (pf_up_count),
    .pf_down_count (pf_down_count)
  );

  // R3: a repeat of the last line raises no request
  p_repeat_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && !line_changed) |=> !pf_valid);

  // R10: request addresses are line aligned
  p_line_aligned_r10: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> pf_addr[LINE_BITS-1:0] == '0);

  // R10: request is a single-cycle pulse unless another strobe follows
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !accept) |=> !pf_valid);

endmodule

// File: tb/stream_prefetch_trigger_tb.sv
module stream_prefetch_trigger_tb;

  localparam int CNT_W = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = '0;
  logic        pf_valid;
  logic [31:0] pf_addr;
  logic [31:0] pf_up_count;
  logic [31:0] pf_down_count;

  int checks = 0;
  int fails  = 0;
  int exp_up = 0;
  int exp_dn = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  stream_prefetch_trigger #(
    .ADDR_W (32), .LINE_BYTES (64), .PAGE_BITS (12),
    .NUM_STREAMS (8), .RUN_W (4), .PF_DIST (5), .CNT_W (CNT_W)
  ) u_dut (
    .clk (clk), .rst (rst), .flush (flush),
    .miss_valid (miss_valid), .miss_addr (miss_addr),
    .pf_valid (pf_valid), .pf_addr (pf_addr),
    .pf_up_count (pf_up_count), .pf_down_count (pf_down_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] line_ofs(input logic [31:0] a, input int n);
    return ((a >> 6) + 32'(n)) << 6;
  endfunction

  // dir: 0 none, 1 up, 2 down
  task automatic access(input logic [31:0] a, input int dir, input string req);
    logic [31:0] exp_a;
    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    @(negedge clk);
    miss_valid = 1'b0;
    if (dir == 1) exp_up++;
    if (dir == 2) exp_dn++;
    check(pf_valid == (dir != 0), req, "pf_valid", 64'(pf_valid), 64'(dir != 0));
    if (dir != 0) begin
      exp_a = line_ofs(a, (dir == 1) ? 5 : -5);
      check(pf_addr == exp_a, req, "pf_addr", 64'(pf_addr), 64'(exp_a));
    end
    check(pf_up_count == 32'(exp_up), req, "up count", 64'(pf_up_count), 64'(exp_up));
    check(pf_down_count == 32'(exp_dn), req, "down count", 64'(pf_down_count), 64'(exp_dn));
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset_r1();
    check(pf_valid == 1'b0, "R1", "pf_valid after reset", 64'(pf_valid), 0);
    check(pf_up_count == 0, "R1", "up count after reset", 64'(pf_up_count), 0);
    check(pf_down_count == 0, "R1", "down count after reset", 64'(pf_down_count), 0);
  endtask

  task automatic t_ascend_r5();
    logic [31:0] b = 32'h1000_0010;
    access(b, 0, "R4");
    access(line_ofs(b, 1) + 32'h8, 0, "R4");
    access(line_ofs(b, 2) + 32'h3, 1, "R5");
    access(line_ofs(b, 3) + 32'h3F, 1, "R5");
  endtask

  task automatic t_repeat_r3();
    logic [31:0] b = 32'h1100_1000;
    access(b, 0, "R4");
    access(line_ofs(b, 1), 0, "R4");
    access(line_ofs(b, 2), 1, "R5");
    access(line_ofs(b, 2) + 32'h20, 0, "R3");
    access(line_ofs(b, 2) + 32'h4, 0, "R3");
    access(line_ofs(b, 3), 1, "R3");
  endtask

  task automatic t_descend_r6();
    logic [31:0] b = 32'h2000_3F84;
    access(b, 0, "R4");
    access(line_ofs(b, -1), 0, "R4");
    access(line_ofs(b, -2) + 32'h11, 2, "R6");
    access(line_ofs(b, -3), 2, "R6");
  endtask

  task automatic t_break_r7();
    logic [31:0] b = 32'h1200_4000;
    access(b, 0, "R4");
    access(line_ofs(b, 1), 0, "R4");
    access(line_ofs(b, 2), 1, "R5");
    access(line_ofs(b, 5), 0, "R7");
    access(line_ofs(b, 6), 0, "R7");
    access(line_ofs(b, 7), 1, "R7");
    // reversal: +run then -1 steps clears first, then starts negative
    access(line_ofs(b, 6), 0, "R7");
    access(line_ofs(b, 5), 0, "R7");
    access(line_ofs(b, 4), 2, "R7");
    access(line_ofs(b, 5), 0, "R7");
  endtask

  task automatic t_slots_r2();
    logic [31:0] pa = 32'h3000_1000;
    logic [31:0] pb = 32'h3000_2000;
    logic [31:0] pc = 32'h3000_9000;
    // different slots: independent runs
    access(pa, 0, "R2");
    access(pb, 0, "R2");
    access(line_ofs(pa, 1), 0, "R2");
    access(line_ofs(pb, 1), 0, "R2");
    access(line_ofs(pa, 2), 1, "R2");
    access(line_ofs(pb, 2), 1, "R2");
    // aliasing slots: pa and pc share slot 1, interleaving destroys the run
    do_flush();
    access(line_ofs(pa, 10), 0, "R2");
    access(line_ofs(pc, 11), 0, "R2");
    access(line_ofs(pa, 11), 0, "R2");
    access(line_ofs(pc, 12), 0, "R2");
    access(line_ofs(pa, 12), 0, "R2");
  endtask

  task automatic t_flush_r8();
    logic [31:0] b = 32'h4000_5000;
    access(b, 0, "R8");
    access(line_ofs(b, 1), 0, "R8");
    do_flush();
    check(pf_up_count == 32'(exp_up), "R8", "up count kept over flush",
          64'(pf_up_count), 64'(exp_up));
    access(line_ofs(b, 2), 0, "R8");
    access(line_ofs(b, 3), 0, "R8");
    access(line_ofs(b, 4), 1, "R8");
    // strobe coinciding with flush is dropped
    @(negedge clk);
    flush = 1'b1; miss_valid = 1'b1; miss_addr = line_ofs(b, 5);
    @(negedge clk);
    flush = 1'b0; miss_valid = 1'b0;
    check(pf_valid == 1'b0, "R8", "no request with flush", 64'(pf_valid), 0);
    access(line_ofs(b, 5), 0, "R8");
    access(line_ofs(b, 6), 0, "R8");
  endtask

  task automatic t_saturate_r9();
    logic [31:0] b = 32'h5000_0000;
    do_flush();
    for (int i = 0; i < 20; i++)
      access(line_ofs(b, i), (i >= 2) ? 1 : 0, "R9");
    // symmetric on the way down after a fresh start
    do_flush();
    for (int i = 0; i < 20; i++)
      access(line_ofs(b + 32'hFC0, -i), (i >= 2) ? 2 : 0, "R9");
  endtask

  task automatic t_timing_r10();
    logic [31:0] b = 32'h6000_7000;
    access(b, 0, "R10");
    access(line_ofs(b, 1), 0, "R10");
    @(negedge clk);
    miss_valid = 1'b1; miss_addr = line_ofs(b, 2) + 32'h1;
    @(negedge clk);
    miss_valid = 1'b0;
    exp_up++;
    check(pf_valid == 1'b1, "R10", "pulse one cycle after strobe", 64'(pf_valid), 1);
    check(pf_addr[5:0] == 6'd0, "R10", "aligned address", 64'(pf_addr[5:0]), 0);
    @(negedge clk);
    check(pf_valid == 1'b0, "R10", "pulse lasts one cycle", 64'(pf_valid), 0);
    check(pf_up_count == 32'(exp_up), "R10", "count after pulse",
          64'(pf_up_count), 64'(exp_up));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_r1();
    t_ascend_r5();
    t_repeat_r3();
    t_descend_r6();
    t_break_r7();
    t_slots_r2();
    t_flush_r8();
    t_saturate_r9();
    t_timing_r10();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule